// File: doc/BRIEF.md
# Two-Digit Hex History Display

This block keeps the two most recently accepted hexadecimal key codes and shows them on a dual seven-segment display. The display's segment lines are shared between both digits. A keypad front end sends a 4-bit code together with a single-cycle accept strobe. On each strobe the stored history shifts one place. The newest code goes to the right-hand digit, and the code it replaces moves to the left-hand digit. At all other times the stored codes do not change.

Only one hex-to-segment decoder exists. A slow multiplex tick, nominally near 240 Hz and produced outside the block, advances a digit pointer. The pointer selects which stored code is decoded and which digit-select line is driven low. Each digit is lit for exactly one tick interval in turn, so the two digits get equal on-time. Both the segment lines and the digit selects are active low, which suits high-side PNP digit drivers.

Top module: `hexhist_display`

## Requirements
- R1: The right digit (select bit 0) shows the most recently accepted code, and the left digit (select bit 1) shows the code accepted before it.
- R2: The stored codes change only in a cycle where `key_accept` is high. A changing `key_code`, multiplex ticks and idle cycles leave them unchanged.
- R3: When `key_accept` is sampled high on a clock edge, the left digit takes the right digit's old value and the right digit takes `key_code`. Both are visible after that edge.
- R4: Each cycle with `mux_tick` high moves the display to the other digit after that edge. Without a tick the selected digit does not change.
- R5: `dig_sel_n` is active low, and exactly one of its bits is low at all times: 2'b10 when the right digit is shown, 2'b01 when the left digit is shown.
- R6: `seg_n[0]` through `seg_n[6]` drive segments a through g, and a low level lights a segment. Written active high as {g..a}, codes 0 to F light 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71. This shows A, C, E and F in upper case and b and d in lower case.
- R7: The segment pattern always belongs to the stored code of the digit that is currently selected.
- R8: While reset is asserted and after it is released, both stored codes are 0 and the right digit is selected.
- R9: Accept strobes on consecutive cycles each shift the history, so two back-to-back codes end up in the left and right digits in order.
- R10: When `key_accept` and `mux_tick` are high in the same cycle, both the shift and the digit change take effect after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_code | input | 4 | Hex code of the key being offered |
| key_accept | input | 1 | Single-cycle strobe that accepts `key_code` |
| mux_tick | input | 1 | Single-cycle enable that advances the displayed digit |
| seg_n | output | 7 | Active-low segments, bit 0 = a through bit 6 = g |
| dig_sel_n | output | 2 | Active-low digit selects, bit 0 = right, bit 1 = left |

## Verification
The history and the digit pointer each pass through one register stage, and the outputs are decoded combinationally from those registers. A strobe or tick sampled on one edge therefore shows at the ports right after that same edge. The bench drives every input one nanosecond after a rising edge and reads the ports one nanosecond after the following rising edge, where the result is due. To see the left digit, the bench issues ticks through the normal input and compares each phase against its own model of the history and the pointer.

// File: rtl/hexhist_pkg.sv
package hexhist_pkg;

  localparam int NIBBLE_W = 4;
  localparam int SEG_W    = 7;

  typedef logic [NIBBLE_W-1:0] nibble_t;
  typedef logic [SEG_W-1:0]    seg_t;

  // Active-high segment image, bit 0 = a ... bit 6 = g.
  function automatic seg_t hex_lit_segments(nibble_t v);
    seg_t s;
    case (v)
      4'h0:    s = 7'h3F;
      4'h1:    s = 7'h06;
      4'h2:    s = 7'h5B;
      4'h3:    s = 7'h4F;
      4'h4:    s = 7'h66;
      4'h5:    s = 7'h6D;
      4'h6:    s = 7'h7D;
      4'h7:    s = 7'h07;
      4'h8:    s = 7'h7F;
      4'h9:    s = 7'h6F;
      4'hA:    s = 7'h77;
      4'hB:    s = 7'h7C;
      4'hC:    s = 7'h39;
      4'hD:    s = 7'h5E;
      4'hE:    s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/digit_history.sv
module digit_history
  import hexhist_pkg::*;
#(
  parameter int NUM_DIGITS = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           accept,
  input  nibble_t                        code,
  output logic [NUM_DIGITS*NIBBLE_W-1:0] hist_flat
);

  // Named event for assertions: history shifts this cycle.
  logic shift_evt;
  assign shift_evt = accept;

  // Slot 0 is the newest (rightmost) digit; each higher slot is older.
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_slot
    nibble_t slot_q;
    nibble_t slot_d;

    if (i == 0) begin : g_newest
      assign slot_d = code;
    end else begin : g_older
      assign slot_d = hist_flat[(i-1)*NIBBLE_W +: NIBBLE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         slot_q <= '0;
      else if (shift_evt) slot_q <= slot_d;
    end

    assign hist_flat[i*NIBBLE_W +: NIBBLE_W] = slot_q;

    if (i > 0) begin : g_chk_older
      AST_OLDER_TAKES_NEWER: assert property (@(posedge clk) disable iff (!rst_n)
        shift_evt |=> hist_flat[i*NIBBLE_W +: NIBBLE_W] == $past(hist_flat[(i-1)*NIBBLE_W +: NIBBLE_W])); // R3
    end
  end

  AST_NEWEST_TAKES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> hist_flat[NIBBLE_W-1:0] == $past(code)); // R1

  AST_HOLD_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(hist_flat)); // R2

endmodule

// File: rtl/digit_alternator.sv
module digit_alternator #(
  parameter int NUM_DIGITS = 2,
  localparam int SLOT_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  output logic [SLOT_W-1:0]     slot_idx,
  output logic [NUM_DIGITS-1:0] sel_onehot
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_DIGITS - 1);

  // Named event for assertions: pointer moves this cycle.
  logic advance_evt;
  assign advance_evt = tick;

  logic [SLOT_W-1:0] slot_q;

  // Each slot keeps the display for exactly one tick interval.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (advance_evt) begin
      if (slot_q == LAST_SLOT) slot_q <= '0;
      else                     slot_q <= slot_q + 1'b1;
    end
  end

  assign slot_idx = slot_q;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_sel
    assign sel_onehot[i] = (slot_q == SLOT_W'(i));
  end

  AST_POINTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_evt |=> $stable(slot_q)); // R4

  if (NUM_DIGITS > 1) begin : g_chk_move
    AST_POINTER_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      advance_evt |=> slot_q != $past(slot_q)); // R4
  end

endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import hexhist_pkg::*;
(
  input  nibble_t value,
  output seg_t    seg_n
);

  // Single shared decoder; active-low drive.
  assign seg_n = ~hex_lit_segments(value);

  always_comb begin
    AST_DIGIT_NEVER_BLANK: assert (seg_n != '1); // R6
  end

endmodule

// File: rtl/hexhist_display.sv
module hexhist_display
  import hexhist_pkg::*;
#(
  parameter int NUM_DIGITS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            key_code,
  input  logic                  key_accept,
  input  logic                  mux_tick,
  output logic [6:0]            seg_n,
  output logic [NUM_DIGITS-1:0] dig_sel_n
);

  localparam int SLOT_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

  logic [NUM_DIGITS*NIBBLE_W-1:0] hist_flat;
  logic [SLOT_W-1:0]              slot_idx;
  logic [NUM_DIGITS-1:0]          sel_onehot;
  nibble_t                        digit_arr [NUM_DIGITS];
  nibble_t                        shown_digit;

  digit_history #(.NUM_DIGITS(NUM_DIGITS)) u_history (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (key_accept),
    .code      (key_code),
    .hist_flat (hist_flat)
  );

  digit_alternator #(.NUM_DIGITS(NUM_DIGITS)) u_alternator (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (mux_tick),
    .slot_idx   (slot_idx),
    .sel_onehot (sel_onehot)
  );

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_unpack
    assign digit_arr[i] = hist_flat[i*NIBBLE_W +: NIBBLE_W];
  end

  // Shared decoder input steered by the multiplex pointer.
  assign shown_digit = digit_arr[slot_idx];

  seg_decoder u_decoder (
    .value (shown_digit),
    .seg_n (seg_n)
  );

  assign dig_sel_n = ~sel_onehot;

  AST_ONE_DIGIT_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dig_sel_n) == 1); // R5

  AST_RIGHT_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> dig_sel_n[0] == 1'b0 || rst_n); // R8

endmodule

// File: tb/test_hexhist_display.sv
module test_hexhist_display;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] key_code;
  logic       key_accept;
  logic       mux_tick;
  logic [6:0] seg_n;
  logic [1:0] dig_sel_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [3:0] m_right, m_left;
  logic       m_on_left;

  always #2 clk = ~clk;

  hexhist_display i_hexhist_display (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_code   (key_code),
    .key_accept (key_accept),
    .mux_tick   (mux_tick),
    .seg_n      (seg_n),
    .dig_sel_n  (dig_sel_n)
  );

  // Per-segment lit sets over codes 0..F (bit k = code k), from R6.
  function automatic logic [6:0] ref_seg_n(logic [3:0] v);
    logic [15:0] lit [7];
    logic [6:0]  r;
    lit[0] = 16'hD7ED; lit[1] = 16'h279F; lit[2] = 16'h2FFB; lit[3] = 16'h7B6D;
    lit[4] = 16'hFD45; lit[5] = 16'hDF71; lit[6] = 16'hEF7C;
    for (int s = 0; s < 7; s++) r[s] = ~lit[s][v];
    return r;
  endfunction

  task automatic check(string req);
    logic [1:0] es;
    logic [6:0] eg;
    es = m_on_left ? 2'b01 : 2'b10;
    eg = ref_seg_n(m_on_left ? m_left : m_right);
    n_tests++;
    if (dig_sel_n !== es || seg_n !== eg) begin
      n_fail++;
      $display("FAIL %s: sel=%b seg=%b expected sel=%b seg=%b", req, dig_sel_n, seg_n, es, eg);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic press(logic [3:0] c);
    key_code = c; key_accept = 1'b1;
    step();
    key_accept = 1'b0;
    m_left = m_right; m_right = c;
  endtask

  task automatic tick();
    mux_tick = 1'b1;
    step();
    mux_tick = 1'b0;
    m_on_left = ~m_on_left;
  endtask

  task automatic look(string req);
    check(req); tick(); check(req); tick(); check(req);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; key_code = 4'h9; key_accept = 1'b0; mux_tick = 1'b0;
    m_right = 4'h0; m_left = 4'h0; m_on_left = 1'b0;
    step(); step();
    check("R8 in reset");
    rst_n = 1'b1;
    step();
    look("R8 after reset");
  endtask

  task automatic t_single();
    press(4'h5);
    look("R1 single key");
  endtask

  task automatic t_two();
    press(4'hA); step(); press(4'h3);
    look("R3 two keys shift");
  endtask

  task automatic t_hold();
    for (int k = 0; k < 6; k++) begin
      key_code = 4'(k * 5); step();
    end
    tick(); step(); tick();
    look("R2 no accept keeps digits");
  endtask

  task automatic t_all_codes();
    for (int v = 0; v < 16; v++) begin
      press(4'(v));
      check("R6 code pattern");
      tick();
      check("R7 shared decoder follows select");
    end
  endtask

  task automatic t_back_to_back();
    press(4'hC); press(4'h7);
    look("R9 back-to-back accepts");
  endtask

  task automatic t_tick_holds();
    tick();
    for (int k = 0; k < 4; k++) begin step(); check("R4 select holds without tick"); end
    tick(); check("R5 right select code");
    tick(); check("R5 left select code");
  endtask

  task automatic t_same_cycle();
    key_code = 4'hE; key_accept = 1'b1; mux_tick = 1'b1;
    step();
    key_accept = 1'b0; mux_tick = 1'b0;
    m_left = m_right; m_right = 4'hE; m_on_left = ~m_on_left;
    look("R10 accept with tick");
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_two();
    t_hold();
    t_all_codes();
    t_back_to_back();
    t_tick_holds();
    t_same_cycle();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule